// File: doc/BRIEF.md
# SPI Master Transfer Engine with Programmable Timing

This block runs one full-duplex SPI word exchange per frame as the bus master. It drives the slave-select line low, waits a programmable settling time, and then toggles the serial clock. It shifts the transmit word out most significant bit first on MOSI and samples MISO on every rising clock edge. After the last bit it releases slave select and then holds off the next frame for a programmable gap. The bit-clock divider, the settling time, the gap and the word length are all configuration inputs. They are captured when a frame starts and are held for the rest of that frame.

A frame begins when the transmit port offers a word (`tx_valid` while the engine is idle) or when `start` is pulsed. If `start` begins a frame with no word offered, the engine sends zeros and flags an underrun. The received word is presented for one cycle on the receive port. If the consumer is not ready in that cycle, the word is lost and an overrun is flagged. The gap between frames is timed on a separate clock-enable, `bus_tick`, and not on the main clock.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset, `ss_n` is 1, `sclk` is 0, `mosi` is 0, `tx_ready` is 1 and `rx_valid` is 0.
- R2: One bit period lasts N = max(`cfg_div`, 3) + 1 clock cycles. `sclk` is high for floor(N/2) cycles after each rising edge and low for the rest of the period.
- R3: A programmed `cfg_div` of 0, 1 or 2 behaves exactly like 3, which gives N = 4.
- R4: The first rising edge of `sclk` comes exactly 32 × (`cfg_settle` + 1) clock cycles after `ss_n` falls.
- R5: `cfg_width` selects the word length: 0→8, 1→12, 2→16, 3→20, 4→24, and 5, 6 or 7→32 bits. A frame has exactly that many rising `sclk` edges.
- R6: The engine uses SPI mode 0. `sclk` is low whenever `ss_n` is high. `mosi` never changes while `sclk` is high. The bits on `mosi` at the rising edges are the low W bits of the transmit word, most significant first.
- R7: The bits on `miso` sampled at the rising edges form `rx_data`, first sample in the most significant of the low W bits. `rx_valid` is high for exactly one cycle, in the cycle in which `ss_n` returns high.
- R8: `ss_n` returns high floor(N/2) cycles after the last rising `sclk` edge, together with the final falling edge of `sclk`.
- R9: After `ss_n` rises, the next frame cannot start until `cfg_gap` + 2 `bus_tick` pulses have been counted. With a word already waiting, the next `ss_n` fall follows the last counted tick within two clock cycles.
- R10: A frame started by `start` with `tx_valid` low sends all zeros. `tx_underrun` is high for one cycle, the cycle in which `ss_n` falls. A frame started with a word does not raise `tx_underrun`.
- R11: `rx_overrun` is high exactly when `rx_valid` is high and `rx_ready` is low.
- R12: Changing `cfg_div`, `cfg_settle`, `cfg_width` or `cfg_gap` while `ss_n` is low does not affect the frame in progress.
- R13: `tx_ready` is high only while the engine is idle. A word offered while `tx_ready` is high is taken at the next clock edge and starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_tick | input | 1 | Clock-enable that paces the inter-frame gap |
| cfg_div | input | DIV_W | Bit-clock divider; one bit lasts cfg_div+1 cycles, minimum 4 |
| cfg_settle | input | SETTLE_W | Delay from select to first clock edge, in units of 32 cycles, minus one |
| cfg_gap | input | GAP_W | Inter-frame gap in bus_tick pulses, minus two |
| cfg_width | input | 3 | Word length code |
| start | input | 1 | Begins a frame even when no word is offered |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 32 | Transmit word, right aligned |
| tx_ready | output | 1 | Engine idle, word will be taken |
| rx_ready | input | 1 | Consumer can take the received word |
| rx_valid | output | 1 | Received word present (one cycle) |
| rx_data | output | 32 | Received word, right aligned |
| rx_overrun | output | 1 | Received word dropped |
| tx_underrun | output | 1 | Frame started with no word to send |
| sclk | output | 1 | Serial clock |
| ss_n | output | 1 | Slave select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
On every cycle, the assertions check the rules about line states: the clock stays low while the slave is deselected, MOSI holds still while the clock is high, and the engine never reports ready during a frame. They also check the timing of the status pulses: the received word appears for a single cycle exactly when select is released, and an underrun coincides with the fall of select. Only the bench scenarios show the cycle counts: the settle time, the bit period and high phase, the divider clamp, the number of clock edges for each width code, the gap measured in ticks, and that configuration changes made during a frame are ignored. The bench scenarios are also the only place where the data itself is compared, in both directions.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    localparam int WORD_MAX = 32;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_HIGH,
        PH_LOW,
        PH_GAP
    } phase_t;

    // Word length for a width code; codes 5..7 give the full 32 bits.
    function automatic logic [5:0] word_bits(input logic [2:0] code);
        if (code >= 3'd5) begin
            return 6'd32;
        end
        return 6'd8 + {1'b0, code, 2'b00};
    endfunction

endpackage

// File: rtl/spi_xfer_timing.sv
module spi_xfer_timing #(
    parameter int DIV_W    = 8,
    parameter int SETTLE_W = 8,
    parameter int CNT_W    = 14
) (
    input  logic [DIV_W-1:0]    div_raw,
    input  logic [SETTLE_W-1:0] settle_raw,
    input  logic [DIV_W:0]      n_held,
    output logic [DIV_W:0]      n_next,
    output logic [CNT_W-1:0]    settle_load,
    output logic [CNT_W-1:0]    hi_load,
    output logic [CNT_W-1:0]    lo_load
);
    localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(3);
    localparam logic [DIV_W:0]   N_ONE     = (DIV_W+1)'(1);
    localparam logic [CNT_W-1:0] C_ONE     = CNT_W'(1);

    logic [DIV_W-1:0]  div_eff;
    logic [DIV_W:0]    hi_len;
    logic [DIV_W:0]    lo_len;
    logic [CNT_W-1:0]  settle_ext;

    always_comb begin
        div_eff     = (div_raw < DIV_FLOOR) ? DIV_FLOOR : div_raw;
        n_next      = {1'b0, div_eff} + N_ONE;
        hi_len      = n_held >> 1;
        lo_len      = n_held - hi_len;
        hi_load     = {{(CNT_W-DIV_W-1){1'b0}}, hi_len} - C_ONE;
        lo_load     = {{(CNT_W-DIV_W-1){1'b0}}, lo_len} - C_ONE;
        settle_ext  = {{(CNT_W-SETTLE_W){1'b0}}, settle_raw};
        settle_load = ((settle_ext + C_ONE) << 5) - C_ONE;
    end

endmodule

// File: rtl/spi_xfer_gap_timer.sv
module spi_xfer_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] span,
    input  logic             tick,
    output logic             done
);
    localparam int CW = GAP_W + 1;
    localparam logic [CW-1:0] C_TWO = CW'(2);
    localparam logic [CW-1:0] C_ONE = CW'(1);

    logic [CW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (load) begin
            left_d = {1'b0, span} + C_TWO;
        end else if (tick && (left_q != '0)) begin
            left_d = left_q - C_ONE;
        end
        done = (left_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else begin
            left_q <= left_d;
        end
    end

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
    import spi_xfer_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int SETTLE_W = 8,
    parameter int GAP_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_tick,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic [SETTLE_W-1:0] cfg_settle,
    input  logic [GAP_W-1:0]    cfg_gap,
    input  logic [2:0]          cfg_width,
    input  logic                start,
    input  logic                tx_valid,
    input  logic [31:0]         tx_data,
    output logic                tx_ready,
    input  logic                rx_ready,
    output logic                rx_valid,
    output logic [31:0]         rx_data,
    output logic                rx_overrun,
    output logic                tx_underrun,
    output logic                sclk,
    output logic                ss_n,
    output logic                mosi,
    input  logic                miso
);
    localparam int CNT_A = SETTLE_W + 6;
    localparam int CNT_B = DIV_W + 2;
    localparam int CNT_W = (CNT_A > CNT_B) ? CNT_A : CNT_B;
    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

    typedef struct packed {
        phase_t                 phase;
        logic [CNT_W-1:0]       cnt;
        logic [5:0]             bits;
        logic [5:0]             width;
        logic [DIV_W:0]         n;
        logic [GAP_W-1:0]       gap;
        logic [WORD_MAX-1:0]    tx_sh;
        logic [WORD_MAX-1:0]    rx_sh;
        logic [WORD_MAX-1:0]    rx_word;
        logic                   sclk;
        logic                   ss_n;
        logic                   rx_valid;
        logic                   underrun;
    } regs_t;

    regs_t r_d, r_q;

    logic [DIV_W:0]   n_next;
    logic [CNT_W-1:0] settle_load, hi_load, lo_load;
    logic             gap_load, gap_done;
    logic             go;
    logic [5:0]       w_new;

    spi_xfer_timing #(
        .DIV_W   (DIV_W),
        .SETTLE_W(SETTLE_W),
        .CNT_W   (CNT_W)
    ) u_timing (
        .div_raw    (cfg_div),
        .settle_raw (cfg_settle),
        .n_held     (r_q.n),
        .n_next     (n_next),
        .settle_load(settle_load),
        .hi_load    (hi_load),
        .lo_load    (lo_load)
    );

    spi_xfer_gap_timer #(
        .GAP_W(GAP_W)
    ) u_gap (
        .clk  (clk),
        .rst_n(rst_n),
        .load (gap_load),
        .span (r_q.gap),
        .tick (bus_tick),
        .done (gap_done)
    );

    always_comb begin
        r_d        = r_q;
        r_d.rx_valid = 1'b0;
        r_d.underrun = 1'b0;
        gap_load   = 1'b0;
        w_new      = word_bits(cfg_width);
        go         = (r_q.phase == PH_IDLE) && (start || tx_valid);

        unique case (r_q.phase)
            PH_IDLE: begin
                if (go) begin
                    r_d.phase    = PH_SETTLE;
                    r_d.ss_n     = 1'b0;
                    r_d.cnt      = settle_load;
                    r_d.n        = n_next;
                    r_d.gap      = cfg_gap;
                    r_d.width    = w_new;
                    r_d.bits     = '0;
                    r_d.rx_sh    = '0;
                    r_d.tx_sh    = tx_valid ? (tx_data << (6'd32 - w_new)) : '0;
                    r_d.underrun = !tx_valid;
                end
            end
            PH_SETTLE, PH_LOW: begin
                if (r_q.cnt == '0) begin
                    r_d.phase = PH_HIGH;
                    r_d.sclk  = 1'b1;
                    r_d.rx_sh = {r_q.rx_sh[WORD_MAX-2:0], miso};
                    r_d.bits  = r_q.bits + 6'd1;
                    r_d.cnt   = hi_load;
                end else begin
                    r_d.cnt = r_q.cnt - C_ONE;
                end
            end
            PH_HIGH: begin
                if (r_q.cnt == '0) begin
                    r_d.sclk = 1'b0;
                    if (r_q.bits == r_q.width) begin
                        r_d.phase    = PH_GAP;
                        r_d.ss_n     = 1'b1;
                        r_d.rx_valid = 1'b1;
                        r_d.rx_word  = r_q.rx_sh;
                        gap_load     = 1'b1;
                    end else begin
                        r_d.phase = PH_LOW;
                        r_d.tx_sh = r_q.tx_sh << 1;
                        r_d.cnt   = lo_load;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - C_ONE;
                end
            end
            PH_GAP: begin
                if (gap_done) begin
                    r_d.phase = PH_IDLE;
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.phase <= PH_IDLE;
            r_q.ss_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_ready    = (r_q.phase == PH_IDLE);
    assign rx_valid    = r_q.rx_valid;
    assign rx_data     = r_q.rx_word;
    assign rx_overrun  = r_q.rx_valid & ~rx_ready;
    assign tx_underrun = r_q.underrun;
    assign sclk        = r_q.sclk;
    assign ss_n        = r_q.ss_n;
    assign mosi        = r_q.tx_sh[WORD_MAX-1];

endmodule

// File: rtl/spi_xfer_checks.sv
module spi_xfer_checks (
    input logic clk,
    input logic rst_n,
    input logic ss_n,
    input logic sclk,
    input logic mosi,
    input logic tx_ready,
    input logic rx_valid,
    input logic tx_underrun
);

    assert_clock_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> !sclk);

    assert_mosi_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && !ss_n) |-> $stable(mosi));

    assert_busy_not_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_n |-> !tx_ready);

    assert_rx_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_rx_at_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n) |-> rx_valid);

    assert_underrun_at_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |-> $fell(ss_n));

endmodule

bind spi_xfer_master spi_xfer_checks u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .ss_n       (ss_n),
    .sclk       (sclk),
    .mosi       (mosi),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .tx_underrun(tx_underrun)
);

// File: tb/sim_spi_xfer_master.sv
`timescale 1ns/1ps
module sim_spi_xfer_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_tick = 1'b0;
    logic [7:0]  cfg_div = 8'd3;
    logic [7:0]  cfg_settle = 8'd0;
    logic [15:0] cfg_gap = 16'd0;
    logic [2:0]  cfg_width = 3'd0;
    logic        start = 1'b0;
    logic        tx_valid = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_ready;
    logic        rx_ready = 1'b1;
    logic        rx_valid;
    logic [31:0] rx_data;
    logic        rx_overrun;
    logic        tx_underrun;
    logic        sclk, ss_n, mosi;
    logic        miso = 1'b0;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    spi_xfer_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick),
        .cfg_div(cfg_div), .cfg_settle(cfg_settle), .cfg_gap(cfg_gap),
        .cfg_width(cfg_width), .start(start), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .rx_ready(rx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_overrun(rx_overrun),
        .tx_underrun(tx_underrun), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
        .miso(miso)
    );

    // monitor and slave model state
    int          cyc = 0;
    logic        prev_ss = 1'b1, prev_sclk = 1'b0;
    int          fall_cyc, first_rise, last_rise, rises, sfalls;
    int          m_period, m_high, m_release, gticks, m_gap;
    logic [31:0] m_mosi, m_rx, sl_sh;
    logic        m_rxv, m_ov, m_under;
    int          frame_cnt = 0, fall_cnt = 0;
    logic [31:0] slave_word = '0;
    int          slave_w = 8;

    task automatic summary_and_end();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_ss && bus_tick) gticks++;
            if (prev_ss && !ss_n) begin
                fall_cyc = cyc; rises = 0; sfalls = 0; m_mosi = '0;
                m_under = tx_underrun; m_gap = gticks;
                sl_sh = slave_word << (32 - slave_w);
                fall_cnt++;
            end
            if (!prev_sclk && sclk) begin
                rises++;
                m_mosi = {m_mosi[30:0], mosi};
                if (rises == 1) first_rise = cyc;
                else if (rises == 2) m_period = cyc - first_rise;
                last_rise = cyc;
            end
            if (prev_sclk && !sclk) begin
                if (sfalls == 0) m_high = cyc - first_rise;
                sfalls++;
                sl_sh = sl_sh << 1;
            end
            if (!prev_ss && ss_n) begin
                m_release = cyc - last_rise;
                m_rxv = rx_valid; m_rx = rx_data; m_ov = rx_overrun;
                gticks = 0;
                frame_cnt++;
            end
        end
        miso      = sl_sh[31];
        prev_ss   = ss_n;
        prev_sclk = sclk;
        bus_tick  = (cyc % 4 == 0);
        if (cyc >= 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            summary_and_end();
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int wbits(input logic [2:0] code);
        return (code >= 3'd5) ? 32 : 8 + 4 * int'(code);
    endfunction

    task automatic wait_idle();
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
    endtask

    // one frame, checked against the requirements
    task automatic run_frame(input logic [2:0] wc, input logic [7:0] dv,
                             input logic [7:0] st, input logic [31:0] data,
                             input logic [31:0] sw, input bit use_data,
                             input bit rdy, input bit scramble);
        int w, n, hi, old;
        logic [31:0] mask, exp_tx;
        w = wbits(wc);
        n = (dv < 3) ? 4 : int'(dv) + 1;
        hi = n / 2;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
        exp_tx = use_data ? (data & mask) : 32'd0;
        wait_idle();
        cfg_width = wc; cfg_div = dv; cfg_settle = st; cfg_gap = 16'd1;
        slave_word = sw; slave_w = w; rx_ready = rdy;
        old = frame_cnt;
        if (use_data) begin tx_valid = 1'b1; tx_data = data; end
        else start = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0; start = 1'b0;
        if (scramble) begin
            cfg_div = 8'd40; cfg_settle = 8'd5; cfg_width = (wc == 3'd0) ? 3'd5 : 3'd0;
            cfg_gap = 16'd300;
        end
        wait (frame_cnt == old + 1);
        check(first_rise - fall_cyc == 32 * (int'(st) + 1), scramble ? "R12" : "R4",
              "settle cycles", first_rise - fall_cyc, 32 * (int'(st) + 1));
        check(m_period == n, (dv < 3) ? "R3" : (scramble ? "R12" : "R2"),
              "bit period", m_period, n);
        check(m_high == hi, "R2", "high phase", m_high, hi);
        check(rises == w, scramble ? "R12" : "R5", "rising edges", rises, w);
        check(m_release == hi, "R8", "release delay", m_release, hi);
        check(m_mosi == exp_tx, "R6", "mosi word", m_mosi, exp_tx);
        check(m_rxv == 1'b1, "R7", "rx_valid at release", m_rxv, 1);
        check(m_rx == (sw & mask), "R7", "rx_data", m_rx, sw & mask);
        check(m_ov == !rdy, "R11", "rx_overrun", m_ov, !rdy);
        check(m_under == !use_data, "R10", "tx_underrun", m_under, !use_data);
        rx_ready = 1'b1;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(ss_n == 1'b1, "R1", "ss_n", ss_n, 1);
        check(sclk == 1'b0, "R1", "sclk", sclk, 0);
        check(mosi == 1'b0, "R1", "mosi", mosi, 0);
        check(tx_ready == 1'b1, "R1", "tx_ready", tx_ready, 1);
        check(rx_valid == 1'b0, "R1", "rx_valid", rx_valid, 0);
    endtask

    // R9 / R13: a waiting word starts the next frame only after the gap
    task automatic test_gap(input logic [15:0] ct);
        int old;
        wait_idle();
        cfg_width = 3'd0; cfg_div = 8'd3; cfg_settle = 8'd0; cfg_gap = ct;
        slave_word = 32'h5A; slave_w = 8;
        old = frame_cnt;
        tx_valid = 1'b1; tx_data = 32'h11;
        @(negedge clk);
        tx_valid = 1'b0;
        check(tx_ready == 1'b0, "R13", "tx_ready during frame", tx_ready, 0);
        wait (frame_cnt == old + 1);
        old = fall_cnt;
        tx_valid = 1'b1; tx_data = 32'h22;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        wait (fall_cnt == old + 1);
        check(m_gap >= int'(ct) + 2 && m_gap <= int'(ct) + 3, "R9",
              "gap ticks", m_gap, int'(ct) + 2);
        old = frame_cnt;
        wait (frame_cnt == old + 1);
        check(m_mosi == 32'h22, "R13", "queued word sent", m_mosi, 32'h22);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_frame(3'd0, 8'd3,  8'd0, 32'hA5,        32'h3C,        1, 1, 0);
        run_frame(3'd1, 8'd0,  8'd1, 32'hABC,       32'h5A3,       1, 1, 0); // R3
        run_frame(3'd2, 8'd6,  8'd0, 32'h1234_8001, 32'hC0DE,      1, 1, 0); // odd N
        run_frame(3'd3, 8'd4,  8'd0, 32'hF_0F0F,    32'hA_5A5A,    1, 1, 0);
        run_frame(3'd4, 8'd4,  8'd2, 32'h81_7E55,   32'h12_3456,   1, 1, 0);
        run_frame(3'd5, 8'd4,  8'd0, 32'hDEAD_BEEF, 32'h8765_4321, 1, 1, 0);
        run_frame(3'd7, 8'd3,  8'd0, 32'h8000_0001, 32'hFFFF_0000, 1, 1, 0); // R5 code 7
        run_frame(3'd0, 8'd5,  8'd0, 32'h0,         32'hC3,        0, 1, 0); // R10
        run_frame(3'd0, 8'd3,  8'd0, 32'h96,        32'h69,        1, 0, 0); // R11
        run_frame(3'd0, 8'd5,  8'd1, 32'h3C,        32'hA5,        1, 1, 1); // R12
        test_gap(16'd5);
        test_gap(16'd0);
        summary_and_end();
    end

endmodule